// File: doc/BRIEF.md
# Programmable Watchdog Timer with Interrupt/Reset Steering

This block watches for a stalled processor. Software programs one 8-bit control register with a 5-bit multiplier and a 2-bit resolution code. The product of the two sets the timeout, counted in pulses of a shared timebase tick that arrives once every 1/16 s. The timeout restarts whenever software rewrites the register. It also restarts on any rising or falling edge of an asynchronous kick input. A register value with a zero multiplier stops the timer.

When the count runs out, the block sets a watchdog flag. The top bit of the register (the steering bit) then picks one of two actions:
- **Steering 0:** the block pulls the shared active-low interrupt line low. The line stays low until software writes 00h.
- **Steering 1:** the block drives an active-low reset pulse of fixed recovery length. It also clears the register and emits a one-cycle pulse that tells neighbouring logic to clear its frequency-test, alarm-enable and backup-alarm-enable bits.

The interrupt line is shared with an alarm request and with a frequency-test waveform. Either interrupt source takes priority over the test waveform.

Top module: `prog_watchdog`

## Requirements
- R1: After reset the register reads 00h, `irqN` and `rstOutN` are high, and `wdFlag` and `clrEnables` are low.
- R2: The register fields are: bit 7 is steering, bits 6:2 are the multiplier M, and bits 1:0 are the resolution code C. The timeout is M × 4^C ticks, so code 00/01/10/11 gives 1/4/16/64 ticks (1/16, 1/4, 1, 4 s). Expiry happens on the tick that completes that many ticks since the last restart, and `wdFlag` reads 1 from the next clock.
- R3: Any register write restarts the count from zero.
- R4: Each rising or falling edge of `kick` restarts the count. The edge passes through a two-flop synchroniser, so it takes effect at the third clock edge after the change.
- R5: While M is 0, which includes the all-zero value, the timer never expires.
- R6: A one-cycle `flagRd` clears `wdFlag` from the next clock. During the read cycle the flag still reads 1. An expiry in the same cycle as a read leaves the flag set.
- R7: On an expiry with steering 0, `irqN` goes low. It stays low through any nonzero write and returns high only after a write of 00h.
- R8: On an expiry with steering 1, `rstOutN` is low for exactly REC_CYCLES clocks, starting one clock after the expiring tick.
- R9: On an expiry with steering 1, the register reads 00h and `clrEnables` is high for exactly one clock, both from the clock after the expiring tick.
- R10: `irqN` is low whenever the watchdog interrupt or `alarmIrq` is active. Otherwise it follows `ftWave` when `ftOn` is 1 and the register is either 00h or has steering 1. In every other case it is high.
- R11: A write or a synchronised kick edge in the same cycle as the final tick wins, so no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse, one clock wide, one per 1/16 s |
| kick | input | 1 | Asynchronous restart input, both edges count |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write value |
| flagRd | input | 1 | Flag-register read strobe |
| alarmIrq | input | 1 | Alarm interrupt request from the neighbour, active high |
| ftOn | input | 1 | Frequency-test output requested by the neighbour |
| ftWave | input | 1 | Frequency-test waveform level |
| irqN | output | 1 | Shared interrupt/test line, active low |
| rstOutN | output | 1 | Watchdog reset pulse, active low |
| wdFlag | output | 1 | Watchdog flag |
| clrEnables | output | 1 | One-cycle clear pulse for neighbouring enable bits |
| wdReg | output | 8 | Current register value |

## Verification
The bench targets the following cases and the failure each one would expose:
- **Timeout length:** an off-by-one in the timeout compare would expire one tick early or late under every resolution code.
- **Kick timing:** a kick detector that sees only one edge direction, or skips the synchroniser, would let the timer expire during slow toggling, or restart it a cycle too soon.
- **Last-tick collision:** a write or kick that lands on the final tick checks the restart priority. A design that got it wrong would raise a spurious flag.
- **Flag read timing:** a read that clears the flag too early would hide it from that same read.
- **Interrupt hold:** releasing the interrupt on any write, rather than only on 00h, would show as `irqN` going high too soon.
- **Steering-1 expiry:** the bench measures the exact length of the reset pulse and of the clear pulse.
- **Shared-line priority:** the bench drives the frequency-test waveform against both interrupt sources. Wrong gating would let the waveform mask a pending interrupt.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef struct packed {
    logic restart;
    logic expire;
  } wdStrobe_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int MULT_W      = 5,
  parameter int RES_W       = 2,
  parameter int RES_STEP    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        tick,
  input  logic                        kick,
  input  logic                        wrEn,
  input  logic [MULT_W+RES_W:0]       regQ,
  output wdStrobe_t                   st
);
  localparam int CNT_W = MULT_W + RES_STEP * ((1 << RES_W) - 1);

  logic [SYNC_STAGES:0] syncQ;
  logic                 kickEdge;
  logic [MULT_W-1:0]    mult;
  logic [RES_W-1:0]     resCode;
  logic [CNT_W-1:0]     limit;
  logic [CNT_W-1:0]     cnt;
  logic                 active;
  logic                 lastTick;

  // Chain of synchroniser flops, plus one more stage for edge detection.
  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= kick;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= syncQ[g-1];
      end
    end
  endgenerate

  assign kickEdge = syncQ[SYNC_STAGES-1] ^ syncQ[SYNC_STAGES];
  assign mult     = regQ[RES_W +: MULT_W];
  assign resCode  = regQ[RES_W-1:0];
  assign limit    = {{(CNT_W-MULT_W){1'b0}}, mult} << (RES_STEP * int'(resCode));
  assign active   = (mult != '0);
  assign lastTick = tick && active && (cnt == limit - 1'b1);

  assign st.restart = wrEn || kickEdge;
  assign st.expire  = lastTick && !st.restart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cnt <= '0;
    else if (st.restart)       cnt <= '0;
    else if (tick && active)   cnt <= lastTick ? '0 : cnt + 1'b1;
  end

  // R5
  idle_no_expire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mult == '0) |-> !st.expire);

  // R11
  restart_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.restart |=> (cnt == '0));
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int REG_W      = 8,
  parameter int REC_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        st,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             flagRd,
  input  logic             alarmIrq,
  input  logic             ftOn,
  input  logic             ftWave,
  output logic [REG_W-1:0] regQ,
  output logic             irqN,
  output logic             rstOutN,
  output logic             wdFlag,
  output logic             clrEnables
);
  localparam int STEER_BIT = REG_W - 1;
  localparam int REC_W     = $clog2(REC_CYCLES + 1);

  logic             steer;
  logic             irqLatch;
  logic [REC_W-1:0] recCnt;
  logic             ftAllowed;
  logic             rstExpire;

  assign steer     = regQ[STEER_BIT];
  assign rstExpire = st.expire && steer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          regQ <= '0;
    else if (wrEn)      regQ <= wrData;
    else if (rstExpire) regQ <= '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          wdFlag <= 1'b0;
    else if (st.expire) wdFlag <= 1'b1;
    else if (flagRd)    wdFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          irqLatch <= 1'b0;
    else if (wrEn && (wrData == '0))    irqLatch <= 1'b0;
    else if (st.expire && !steer)       irqLatch <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              recCnt <= '0;
    else if (rstExpire)     recCnt <= REC_W'(REC_CYCLES);
    else if (recCnt != '0)  recCnt <= recCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clrEnables <= 1'b0;
    else       clrEnables <= rstExpire;
  end

  assign rstOutN   = (recCnt == '0);
  assign ftAllowed = (regQ == '0) || steer;
  always_comb begin
    if (irqLatch || alarmIrq)   irqN = 1'b0;
    else if (ftOn && ftAllowed) irqN = ftWave;
    else                        irqN = 1'b1;
  end

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.expire |=> wdFlag);

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqLatch && !(wrEn && (wrData == '0))) |=> irqLatch);

  // R8
  rst_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstOutN) |-> $past(st.expire));

  // R9
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrEnables |=> !clrEnables);

  // R9
  reg_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrEnables |-> (regQ == '0));
endmodule

// File: rtl/prog_watchdog.sv
module prog_watchdog
  import wdog_pkg::*;
#(
  parameter int MULT_W     = 5,
  parameter int RES_W      = 2,
  parameter int REC_CYCLES = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tick,
  input  logic                    kick,
  input  logic                    wrEn,
  input  logic [MULT_W+RES_W:0]   wrData,
  input  logic                    flagRd,
  input  logic                    alarmIrq,
  input  logic                    ftOn,
  input  logic                    ftWave,
  output logic                    irqN,
  output logic                    rstOutN,
  output logic                    wdFlag,
  output logic                    clrEnables,
  output logic [MULT_W+RES_W:0]   wdReg
);
  localparam int REG_W = MULT_W + RES_W + 1;

  wdStrobe_t st;

  wdog_ctrl #(
    .MULT_W(MULT_W), .RES_W(RES_W), .RES_STEP(2), .SYNC_STAGES(2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .kick(kick),
    .wrEn(wrEn), .regQ(wdReg), .st(st)
  );

  wdog_dp #(
    .REG_W(REG_W), .REC_CYCLES(REC_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrEn(wrEn), .wrData(wrData),
    .flagRd(flagRd), .alarmIrq(alarmIrq), .ftOn(ftOn), .ftWave(ftWave),
    .regQ(wdReg), .irqN(irqN), .rstOutN(rstOutN), .wdFlag(wdFlag),
    .clrEnables(clrEnables)
  );
endmodule

// File: tb/prog_watchdog_tb.sv
module prog_watchdog_tb;
  localparam int REC = 16;

  logic clk = 0, rstN = 0, tick = 1, kick = 0, wrEn = 0, flagRd = 0;
  logic alarmIrq = 0, ftOn = 0, ftWave = 0;
  logic [7:0] wrData = 0;
  logic irqN, rstOutN, wdFlag, clrEnables;
  logic [7:0] wdReg;

  int compared = 0, mismatched = 0, cycles = 0;

  prog_watchdog #(.REC_CYCLES(REC)) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .kick(kick), .wrEn(wrEn),
    .wrData(wrData), .flagRd(flagRd), .alarmIrq(alarmIrq), .ftOn(ftOn),
    .ftWave(ftWave), .irqN(irqN), .rstOutN(rstOutN), .wdFlag(wdFlag),
    .clrEnables(clrEnables), .wdReg(wdReg)
  );

  always #5 clk = ~clk;

  // Behavioural reference model
  int   mCnt, mRec, mLim, mMult;
  logic [7:0] mReg;
  logic mFlag, mIrq, mClr, expNow, edgeNow;
  logic kq[$];

  initial begin
    mCnt = 0; mRec = 0; mReg = 0; mFlag = 0; mIrq = 0; mClr = 0;
    kq = '{1'b0, 1'b0, 1'b0};
  end

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mCnt = 0; mRec = 0; mReg = 0; mFlag = 0; mIrq = 0; mClr = 0;
      kq = '{1'b0, 1'b0, 1'b0};
    end else begin
      edgeNow = kq[1] ^ kq[2];
      mMult = (mReg >> 2) & 31;
      mLim  = mMult * (4 ** (mReg & 3));
      expNow = !wrEn && !edgeNow && tick && (mMult != 0) && (mCnt == mLim - 1);
      if (wrEn || edgeNow) mCnt = 0;
      else if (tick && mMult != 0) mCnt = expNow ? 0 : mCnt + 1;
      mClr = expNow && mReg[7];
      if (expNow && mReg[7]) mRec = REC; else if (mRec > 0) mRec--;
      if (expNow) mFlag = 1; else if (flagRd) mFlag = 0;
      if (wrEn && wrData == 0) mIrq = 0; else if (expNow && !mReg[7]) mIrq = 1;
      if (wrEn) mReg = wrData; else if (expNow && mReg[7]) mReg = 0;
      void'(kq.pop_back());
      kq.push_front(kick);
    end
  end

  task automatic cmp(string tag, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (rstN) begin
      cmp("R6 wdFlag", {7'b0, wdFlag}, {7'b0, mFlag});
      cmp("R7/R10 irqN", {7'b0, irqN},
          {7'b0, (mIrq || alarmIrq) ? 1'b0 :
                 (ftOn && (mReg == 0 || mReg[7])) ? ftWave : 1'b1});
      cmp("R8 rstOutN", {7'b0, rstOutN}, {7'b0, mRec == 0});
      cmp("R9 clrEnables", {7'b0, clrEnables}, {7'b0, mClr});
      cmp("R2/R9 wdReg", wdReg, mReg);
    end
  end

  task automatic wr(logic [7:0] d);
    @(negedge clk); wrEn = 1; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rdFlag();
    @(negedge clk); flagRd = 1;
    @(negedge clk); flagRd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mainSeq();
    int lowCnt, clrCnt;
    idle(4);
    @(negedge clk); rstN = 1;
    @(negedge clk);
    // R1 reset state
    cmp("R1 wdReg", wdReg, 8'h00);
    cmp("R1 irqN", {7'b0, irqN}, 8'h01);
    cmp("R1 rstOutN", {7'b0, rstOutN}, 8'h01);
    cmp("R1 wdFlag", {7'b0, wdFlag}, 8'h00);
    cmp("R1 clrEnables", {7'b0, clrEnables}, 8'h00);

    // R2 timing: M=3, C=00 -> 3 ticks
    wr(8'h0C);
    @(posedge clk); @(posedge clk); #3;
    cmp("R2 flag before 3rd tick", {7'b0, wdFlag}, 8'h00);
    @(posedge clk); #3;
    cmp("R2 flag after 3rd tick", {7'b0, wdFlag}, 8'h01);
    cmp("R7 irq asserted", {7'b0, irqN}, 8'h00);
    // R6 read returns 1, clears afterwards
    @(negedge clk); flagRd = 1; wrEn = 1; wrData = 8'h00;
    #1 cmp("R6 flag during read", {7'b0, wdFlag}, 8'h01);
    @(negedge clk); flagRd = 0; wrEn = 0;
    cmp("R6 flag after read", {7'b0, wdFlag}, 8'h00);

    // R7 nonzero write keeps irq
    wr(8'h0C); idle(6);
    wr(8'h0C);
    cmp("R7 irq held on nonzero write", {7'b0, irqN}, 8'h00);
    wr(8'h00);
    cmp("R7 irq released by 00h", {7'b0, irqN}, 8'h01);
    rdFlag();

    // R5 zero multiplier
    wr(8'h03); idle(300);
    cmp("R5 no expiry with M=0", {7'b0, wdFlag}, 8'h00);

    // R3 rewrites restart
    wr(8'h14);
    for (int i = 0; i < 10; i++) begin idle(2); wr(8'h14); end
    cmp("R3 no expiry under rewrites", {7'b0, wdFlag}, 8'h00);
    idle(10); rdFlag(); wr(8'h00);

    // R4 kick edges both directions, C=01 -> 20 ticks
    wr(8'h15);
    for (int i = 0; i < 14; i++) begin idle(8); kick = ~kick; end
    cmp("R4 no expiry under kicks", {7'b0, wdFlag}, 8'h00);
    idle(30); rdFlag(); wr(8'h00);

    // R8/R9 steering 1: M=2, C=10 -> 32 ticks
    ftOn = 1; ftWave = 1;
    wr(8'h8A);
    lowCnt = 0; clrCnt = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #3;
      if (!rstOutN) lowCnt++;
      if (clrEnables) clrCnt++;
    end
    cmp("R8 reset pulse length", 8'(lowCnt), 8'(REC));
    cmp("R9 clear pulse count", 8'(clrCnt), 8'h01);
    cmp("R9 register cleared", wdReg, 8'h00);
    rdFlag();

    // R10 priority on shared line
    for (int i = 0; i < 8; i++) begin @(negedge clk); ftWave = ~ftWave; end
    @(negedge clk); ftWave = 0;
    @(negedge clk);
    cmp("R10 ft passes with reg 00h", {7'b0, irqN}, 8'h00);
    alarmIrq = 1; ftWave = 1;
    @(negedge clk);
    cmp("R10 alarm beats ft", {7'b0, irqN}, 8'h00);
    alarmIrq = 0;
    wr(8'h7C);
    cmp("R10 ft blocked when steering to irq", {7'b0, irqN}, 8'h01);
    wr(8'h00); ftOn = 0;

    // R11 collision of write with final tick; sparse ticks
    tick = 0;
    wr(8'h08);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    @(negedge clk); tick = 1; wrEn = 1; wrData = 8'h08;
    @(negedge clk); tick = 0; wrEn = 0;
    cmp("R11 write beats final tick", {7'b0, wdFlag}, 8'h00);

    // R2 sparse ticks, C=11 with M=1 -> 64 ticks
    wr(8'h07);
    for (int i = 0; i < 70; i++) begin
      @(negedge clk); tick = 1; @(negedge clk); tick = 0; idle(1);
    end
    cmp("R2 expiry with C=11", {7'b0, wdFlag}, 8'h01);
    wr(8'h00); rdFlag(); tick = 1;
    idle(5);
  endtask

  initial begin
    fork
      mainSeq();
      begin
        wait (cycles > 150000);
        mismatched++;
        $display("FAIL watchdog expired: actual hung expected finish");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule